// File: doc/BRIEF.md
# Bus Mastership Handshake Controller

This block is the requester side of a shared external bus that several masters use in turn. An external arbiter hands out an active-low grant. The shared active-low busy line is the wired-AND of the acknowledge lines of all masters. The block takes a request from the CPU or DMA side. It waits for a grant, then waits for the previous owner to free the busy line. Only then does it pull its own acknowledge low and hold the bus.

Once it owns the bus, the block keeps it (parking) for as long as the grant stays low, even after the request goes away. If the grant is removed during an indivisible read-modify-write, ownership is held until the instruction-end strobe. On release, the acknowledge pin is driven high for half a clock. The driver is then switched off, so a weak pull-up keeps the line high. The bus-owned status equals the asserted acknowledge and can enable the external address and data buffers.

Top module: `bus_master_handshake`

## Requirements
- R1: After a grant, acknowledge (`ack_n` low with `ack_oe` high) is asserted only on the first rising edge at which `busy_n` is sampled high. While `busy_n` is sampled low, no ownership is taken.
- R2: `bus_owned` is 1 exactly when acknowledge is asserted (`ack_oe`=1, `ack_n`=0). While not owning, `ack_n` reads 1.
- R3: While owning with `grant_n` low, ownership is kept however `req` changes (parking).
- R4: While owning with `rmw_lock` high and `instr_end` low, ownership is kept even with `grant_n` high.
- R5: A lock seen during ownership keeps the bus after `rmw_lock` falls. It lasts until a cycle with `instr_end` high. The release then happens on that edge if `grant_n` is high.
- R6: On release, `ack_oe` stays high with `ack_n`=1 from the release rising edge until the following falling edge, and is 0 after that.
- R7: While `rst_n` is low, `ack_oe` and `bus_owned` are 0 whatever `grant_n` does. Reset acts immediately, without a clock.
- R8: A pending request whose grant is withdrawn before `busy_n` frees returns to idle. A later rise of `busy_n` without a grant does not give ownership.
- R9: From idle, a grant with `req` low is ignored. A grant with `req` high moves to pending on that edge.
- R10: With no lock, a parked owner seeing `grant_n` high negates acknowledge on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| req | input | 1 | Bus request from the CPU or DMA side |
| rmw_lock | input | 1 | Indivisible read-modify-write in progress |
| instr_end | input | 1 | One-cycle strobe at the end of the current instruction |
| grant_n | input | 1 | Active-low grant from the external arbiter |
| busy_n | input | 1 | Active-low shared busy line (wired-AND of all acknowledges) |
| ack_n | output | 1 | Drive value for the acknowledge pin |
| ack_oe | output | 1 | Output enable of the acknowledge driver (0 = high-Z) |
| bus_owned | output | 1 | Bus owned; enable for external buffers |

## Verification
Acquisition is tried in two ways. In one, the busy line is held low by another master for several cycles before it frees. In the other, the line is free at once. Together they separate waiting on busy from waiting on grant. Release is tried four ways: grant removal while parked, during a live lock, after a lock flag has dropped but before instruction end, and during pending. This shows that each hold condition is kept apart from the others. The output enable is sampled after both the rising and the falling edge around a release, to confirm the half-cycle drive. Reset is applied while the grant is low and also while owning.

// File: rtl/bmh_pkg.sv
package bmh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_OWN  = 2'd2
  } bmh_state_e;

  // Release condition when owning: grant gone and no lock, or lock ends now
  function automatic logic may_release(input logic grant_n, input logic locked,
                                       input logic instr_end);
    return grant_n && (!locked || instr_end);
  endfunction
endpackage

// File: rtl/bmh_lock_track.sv
module bmh_lock_track (
  input  logic clk,
  input  logic rst_n,
  input  logic owning,
  input  logic rmw_lock,
  input  logic instr_end,
  output logic locked
);
  logic lock_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lock_seen_q <= 1'b0;
    else if (!owning || instr_end)
      lock_seen_q <= 1'b0;
    else if (rmw_lock)
      lock_seen_q <= 1'b1;
  end

  assign locked = rmw_lock | lock_seen_q;
endmodule

// File: rtl/bmh_master_fsm.sv
module bmh_master_fsm
  import bmh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic grant_n,
  input  logic busy_n,
  input  logic locked,
  input  logic rmw_lock,
  input  logic instr_end,
  output logic owning,
  output logic release_ev
);
  bmh_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (!grant_n && req) state_d = ST_PEND;
      ST_PEND: begin
        if (grant_n)     state_d = ST_IDLE;
        else if (busy_n) state_d = ST_OWN;
      end
      ST_OWN:  if (may_release(grant_n, locked, instr_end)) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign owning     = (state_q == ST_OWN);
  assign release_ev = (state_q == ST_OWN) && (state_d != ST_OWN);

  // R1: no ownership taken while busy is held low
  p_no_ack_while_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!owning && !busy_n) |=> !owning);
  // R3: parking keeps the bus while grant stays
  p_park_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (owning && !grant_n) |=> owning);
  // R4: live lock keeps the bus
  p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (owning && rmw_lock && !instr_end) |=> owning);
  // R5: remembered lock keeps the bus until instruction end
  p_lock_until_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (owning && locked && !instr_end) |=> owning);
  // R8: no ownership without grant
  p_no_take_without_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!owning && grant_n) |=> !owning);
  // R10: unlocked owner leaves on next edge after grant removal
  p_unlocked_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (owning && grant_n && !locked) |=> !owning);
endmodule

// File: rtl/bmh_release_drive.sv
module bmh_release_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic owning,
  input  logic release_ev,
  output logic drive_en
);
  logic rel_q;     // set for the cycle after the release edge
  logic neg_seen_q; // falling-edge capture ends the high drive

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= 1'b0;
    else        rel_q <= release_ev;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_seen_q <= 1'b0;
    else        neg_seen_q <= rel_q;
  end

  assign drive_en = owning | (rel_q & ~neg_seen_q);

  // R6: the high drive never lasts into a second rising edge
  p_drive_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_q && !owning) |=> !rel_q);
endmodule

// File: rtl/bus_master_handshake.sv
module bus_master_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic rmw_lock,
  input  logic instr_end,
  input  logic grant_n,
  input  logic busy_n,
  output logic ack_n,
  output logic ack_oe,
  output logic bus_owned
);
  logic owning, release_ev, locked;

  bmh_lock_track u_lock (
    .clk(clk), .rst_n(rst_n), .owning(owning), .rmw_lock(rmw_lock),
    .instr_end(instr_end), .locked(locked)
  );

  bmh_master_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req), .grant_n(grant_n), .busy_n(busy_n),
    .locked(locked), .rmw_lock(rmw_lock), .instr_end(instr_end),
    .owning(owning), .release_ev(release_ev)
  );

  bmh_release_drive u_drv (
    .clk(clk), .rst_n(rst_n), .owning(owning), .release_ev(release_ev),
    .drive_en(ack_oe)
  );

  assign ack_n     = ~owning;
  assign bus_owned = owning;

  // R2: owned status matches an asserted acknowledge
  p_owned_is_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_owned == (ack_oe && !ack_n));
  // R6: any drive while not owning is a high drive
  p_release_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_oe && !bus_owned) |-> ack_n);
endmodule

// File: tb/bus_master_handshake_test.sv
module bus_master_handshake_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, rmw_lock = 1'b0, instr_end = 1'b0, grant_n = 1'b1;
  logic other_busy_n = 1'b1;
  logic ack_n, ack_oe, bus_owned, busy_n;
  int checks = 0, failures = 0;

  // wired-AND of the other master and this block's pin (pull-up when high-Z)
  assign busy_n = other_busy_n & (ack_oe ? ack_n : 1'b1);

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_master_handshake uut (
    .clk(clk), .rst_n(rst_n), .req(req), .rmw_lock(rmw_lock),
    .instr_end(instr_end), .grant_n(grant_n), .busy_n(busy_n),
    .ack_n(ack_n), .ack_oe(ack_oe), .bus_owned(bus_owned)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic expect_owned(input string tag, input logic own);
    check({tag, " owned"}, bus_owned, own);
    check({tag, " oe"}, ack_oe, own);
    check({tag, " ack_n"}, ack_n, ~own);
  endtask

  task automatic acquire();
    req = 1'b1; grant_n = 1'b0; other_busy_n = 1'b1;
    tick(2);
    expect_owned("acquire R1", 1'b1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; grant_n = 1'b0; req = 1'b1;
    tick(3);
    check("R7 oe in reset", ack_oe, 1'b0);
    check("R7 owned in reset", bus_owned, 1'b0);
    grant_n = 1'b1; req = 1'b0;
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_wait_busy();
    other_busy_n = 1'b0; req = 1'b1; grant_n = 1'b0;
    tick(1);
    expect_owned("R9 pending", 1'b0);
    tick(3);
    expect_owned("R1 busy low", 1'b0);
    other_busy_n = 1'b1;
    tick(1);
    expect_owned("R1 busy freed", 1'b1);
    check("R2 busy driven low by own ack", busy_n, 1'b0);
  endtask

  task automatic t_park_and_release();
    req = 1'b0;
    tick(4);
    expect_owned("R3 parked", 1'b1);
    grant_n = 1'b1;
    tick(1);
    check("R10 released", bus_owned, 1'b0);
    check("R6 high drive oe", ack_oe, 1'b1);
    check("R6 high drive value", ack_n, 1'b1);
    @(negedge clk); #1;
    check("R6 oe off after fall", ack_oe, 1'b0);
    tick(1);
    check("R6 oe stays off", ack_oe, 1'b0);
  endtask

  task automatic t_lock();
    acquire();
    rmw_lock = 1'b1; grant_n = 1'b1;
    tick(3);
    expect_owned("R4 live lock", 1'b1);
    rmw_lock = 1'b0;
    tick(2);
    expect_owned("R5 remembered lock", 1'b1);
    instr_end = 1'b1;
    tick(1);
    instr_end = 1'b0;
    check("R5 release at end", bus_owned, 1'b0);
    check("R6 drive after lock release", ack_oe, 1'b1);
    tick(1);
  endtask

  task automatic t_pending_abort();
    other_busy_n = 1'b0; req = 1'b1; grant_n = 1'b0;
    tick(2);
    grant_n = 1'b1;
    tick(1);
    other_busy_n = 1'b1;
    tick(3);
    expect_owned("R8 abort", 1'b0);
    req = 1'b0;
  endtask

  task automatic t_no_req();
    req = 1'b0; grant_n = 1'b0; other_busy_n = 1'b1;
    tick(4);
    expect_owned("R9 grant without req", 1'b0);
    req = 1'b1;
    tick(1);
    expect_owned("R9 pending then", 1'b0);
    tick(1);
    expect_owned("R9 owned", 1'b1);
    grant_n = 1'b1; req = 1'b0;
    tick(2);
  endtask

  task automatic t_reset_while_owning();
    acquire();
    #2 rst_n = 1'b0;
    #1;
    check("R7 async drop oe", ack_oe, 1'b0);
    check("R7 async drop owned", bus_owned, 1'b0);
    tick(1);
    grant_n = 1'b1; req = 1'b0;
    rst_n = 1'b1;
    tick(1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_wait_busy();
    t_park_and_release();
    t_lock();
    t_pending_abort();
    t_no_req();
    t_reset_while_owning();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule